// File: doc/BRIEF.md
# Fast Ethernet 4B/5B Transmit Framer

This block sits between a MAC's nibble-wide transmit interface and the later stages of a 100 Mb/s copper transmitter. On every nibble clock it takes one transmit-enable, one transmit-error bit, one 4-bit data nibble and a symbol-mode select. It produces one registered 5-bit code-group. Between frames it sends the idle code-group. When a frame begins it sends the start-of-stream pair /J/ /K/ in the two slots of the first preamble octet. It translates every later nibble through the 4B/5B table. When the enable drops it closes the stream with /T/ /R/.

In symbol mode the translation table and the framing are both skipped. The error input becomes the most significant bit of a raw 5-bit symbol, and that symbol goes out unchanged. Scrambling and line coding come after this block and are not part of it.

Top module: `fx_tx_framer`

## Requirements
- R1: While reset is held, and in the first two nibble clocks after reset, the output is the idle code-group 11111.
- R2: Outside a frame, with symbol mode off and transmit-enable low, the output is idle 11111.
- R3: The first two nibbles of a frame (transmit-enable high after idle) are replaced by J=11000 and then K=10001. The nibble values in those two slots are discarded.
- R4: Every later nibble of the frame, with the error input low, is encoded as follows, written bit 4 down to bit 0. 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R5: A data slot of a frame with the error input high outputs HALT=00100 in place of its data code.
- R6: The first nibble slot with transmit-enable low after a frame outputs T=01101. The next slot outputs R=00111. After that the block is idle again.
- R7: With symbol mode high, the output is {error input, nibble}, with the error input in bit 4, whatever transmit-enable is. Symbol mode also returns the framer to idle, so a frame that is still enabled when symbol mode drops starts again with J, K.
- R8: The code-group for a nibble appears exactly two nibble clocks after that nibble is presented: it is captured on the first rising edge and shown after the second.
- R9: The nibble presented in the R slot is discarded even if transmit-enable is high. A frame can start no earlier than the slot after R, and it starts with J.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable from the MAC |
| tx_er | input | 1 | Transmit error; fifth symbol bit in symbol mode |
| txd | input | 4 | Transmit data nibble |
| sym_mode | input | 1 | Raw 5-bit symbol pass-through select |
| code | output | 5 | Registered code-group |

## Verification
The table is swept with frames of every length from 1 to 20 data nibbles, each carrying a shifted nibble sequence. Together these cover all sixteen codes and show whether J/K replace slots rather than delay them. Inter-frame gaps of zero to three nibbles tell a proper T/R close apart from the case where the enable comes back during the R slot, which must drop the nibble. Error pulses placed at varying positions check that HALT lands only in data slots. All 32 raw symbols are sent in symbol mode with the enable toggled, and symbol mode is also left mid-frame, which shows whether the bypass both ignores framing and resets it.

// File: rtl/fx_pkg.sv
package fx_pkg;
    localparam int NIB_W = 4;
    localparam int CG_W  = NIB_W + 1;

    typedef logic [CG_W-1:0] cg_t;

    localparam cg_t CG_IDLE = 5'b11111;
    localparam cg_t CG_J    = 5'b11000;
    localparam cg_t CG_K    = 5'b10001;
    localparam cg_t CG_T    = 5'b01101;
    localparam cg_t CG_R    = 5'b00111;
    localparam cg_t CG_HALT = 5'b00100;

    typedef enum logic [1:0] {PH_IDLE, PH_K, PH_DATA, PH_R} phase_e;

    typedef struct packed {
        logic             en;
        logic             er;
        logic [NIB_W-1:0] nib;
        logic             raw;
    } smp_s;

    function automatic cg_t fx_data_code(input logic [NIB_W-1:0] n);
        case (n)
            4'h0: fx_data_code = 5'b11110;
            4'h1: fx_data_code = 5'b01001;
            4'h2: fx_data_code = 5'b10100;
            4'h3: fx_data_code = 5'b10101;
            4'h4: fx_data_code = 5'b01010;
            4'h5: fx_data_code = 5'b01011;
            4'h6: fx_data_code = 5'b01110;
            4'h7: fx_data_code = 5'b01111;
            4'h8: fx_data_code = 5'b10010;
            4'h9: fx_data_code = 5'b10011;
            4'hA: fx_data_code = 5'b10110;
            4'hB: fx_data_code = 5'b10111;
            4'hC: fx_data_code = 5'b11010;
            4'hD: fx_data_code = 5'b11011;
            4'hE: fx_data_code = 5'b11100;
            default: fx_data_code = 5'b11101;
        endcase
    endfunction

    function automatic logic fx_is_legal(input cg_t c);
        logic hit;
        hit = (c == CG_IDLE) || (c == CG_J) || (c == CG_K) || (c == CG_T)
           || (c == CG_R) || (c == CG_HALT);
        for (int i = 0; i < (1 << NIB_W); i++) begin
            if (c == fx_data_code(i[NIB_W-1:0])) hit = 1'b1;
        end
        return hit;
    endfunction
endpackage

// File: rtl/fx_in_stage.sv
module fx_in_stage
    import fx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  smp_s smp_in,
    output smp_s smp_q
);
    smp_s smp_d;

    always_comb begin
        smp_d = smp_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= smp_d;
    end
endmodule

// File: rtl/fx_nib_enc.sv
module fx_nib_enc
    import fx_pkg::*;
(
    input  logic [NIB_W-1:0] nib,
    output cg_t              data_code
);
    always_comb begin
        data_code = fx_data_code(nib);
    end
endmodule

// File: rtl/fx_frame_ctl.sv
module fx_frame_ctl
    import fx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  smp_s smp,
    input  cg_t  data_code,
    output cg_t  code_q,
    output logic raw_q
);
    typedef struct packed {
        phase_e ph;
        cg_t    code;
        logic   raw;
    } ctl_s;

    ctl_s r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.raw = smp.raw;
        if (smp.raw) begin
            r_d.code = {smp.er, smp.nib};
            r_d.ph   = PH_IDLE;
        end else begin
            case (r_q.ph)
                PH_IDLE: begin
                    if (smp.en) begin
                        r_d.code = CG_J;
                        r_d.ph   = PH_K;
                    end else begin
                        r_d.code = CG_IDLE;
                    end
                end
                PH_K: begin
                    r_d.code = CG_K;
                    r_d.ph   = PH_DATA;
                end
                PH_DATA: begin
                    if (smp.en) begin
                        r_d.code = smp.er ? CG_HALT : data_code;
                    end else begin
                        r_d.code = CG_T;
                        r_d.ph   = PH_R;
                    end
                end
                default: begin
                    r_d.code = CG_R;
                    r_d.ph   = PH_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.ph   <= PH_IDLE;
            r_q.code <= CG_IDLE;
            r_q.raw  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign code_q = r_q.code;
    assign raw_q  = r_q.raw;

    assert_idle_when_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp.en && !smp.raw && r_q.ph == PH_IDLE) |=> (code_q == CG_IDLE));

    assert_k_after_j_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == CG_K && !raw_q) |-> ($past(code_q) == CG_J && !$past(raw_q)));

    assert_legal_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_q |-> fx_is_legal(code_q));

    assert_halt_in_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == CG_HALT && !raw_q) |-> ($past(r_q.ph) == PH_DATA && $past(smp.er)));

    assert_t_then_r_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == CG_T && !raw_q) |=> (code_q == CG_R || raw_q));
endmodule

// File: rtl/fx_tx_framer.sv
module fx_tx_framer
    import fx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             tx_er,
    input  logic [NIB_W-1:0] txd,
    input  logic             sym_mode,
    output logic [CG_W-1:0]  code
);
    smp_s in_now, in_q;
    cg_t  data_code;
    cg_t  code_int;
    logic raw_int;

    always_comb begin
        in_now.en  = tx_en;
        in_now.er  = tx_er;
        in_now.nib = txd;
        in_now.raw = sym_mode;
    end

    fx_in_stage i_in_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_in (in_now),
        .smp_q  (in_q)
    );

    fx_nib_enc i_nib_enc (
        .nib       (in_q.nib),
        .data_code (data_code)
    );

    fx_frame_ctl i_frame_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp       (in_q),
        .data_code (data_code),
        .code_q    (code_int),
        .raw_q     (raw_int)
    );

    assign code = code_int;

    assert_raw_passthrough_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sym_mode, 2) |-> (code == {$past(tx_er, 2), $past(txd, 2)}));
endmodule

// File: tb/test_fx_tx_framer.sv
module test_fx_tx_framer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       tx_er = 1'b0;
    logic [3:0] txd = 4'h0;
    logic       sym_mode = 1'b0;
    logic [4:0] code;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    logic [4:0] exp_pipe [2];
    string      tag_pipe [2];
    int         m_ph = 0;

    always #5 clk = ~clk;

    fx_tx_framer i_fx_tx_framer (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er),
        .txd(txd), .sym_mode(sym_mode), .code(code)
    );

    function automatic logic [4:0] ref_enc(input logic [3:0] n);
        logic [4:0] tbl [16] = '{5'h1E, 5'h09, 5'h14, 5'h15, 5'h0A, 5'h0B, 5'h0E, 5'h0F,
                                 5'h12, 5'h13, 5'h16, 5'h17, 5'h1A, 5'h1B, 5'h1C, 5'h1D};
        return tbl[n];
    endfunction

    task automatic check(input logic [4:0] exp, input string tag);
        n_chk++;
        if (code !== exp) begin
            n_bad++;
            $display("FAIL %s: code=%b expected=%b at %0t", tag, code, exp, $time);
        end
    endtask

    task automatic model(input logic en, input logic er, input logic [3:0] d,
                         input logic sm, output logic [4:0] c, output string tag);
        if (sm) begin
            c = {er, d}; tag = "R7"; m_ph = 0;
        end else begin
            case (m_ph)
                0: if (en) begin c = 5'b11000; tag = "R3,R8"; m_ph = 1; end
                   else begin c = 5'b11111; tag = "R2"; end
                1: begin c = 5'b10001; tag = "R3"; m_ph = 2; end
                2: if (en) begin
                       if (er) begin c = 5'b00100; tag = "R5"; end
                       else begin c = ref_enc(d); tag = "R4"; end
                   end else begin c = 5'b01101; tag = "R6"; m_ph = 3; end
                default: begin c = 5'b00111; tag = en ? "R9" : "R6"; m_ph = 0; end
            endcase
        end
    endtask

    task automatic step(input logic en, input logic er, input logic [3:0] d, input logic sm);
        logic [4:0] c;
        string t;
        @(negedge clk);
        check(exp_pipe[1], tag_pipe[1]);
        tx_en = en; tx_er = er; txd = d; sym_mode = sm;
        model(en, er, d, sm, c, t);
        exp_pipe[1] = exp_pipe[0]; tag_pipe[1] = tag_pipe[0];
        exp_pipe[0] = c;           tag_pipe[0] = t;
    endtask

    task automatic frame(input int len, input int seed, input int er_at);
        for (int i = 0; i < len + 2; i++)
            step(1'b1, (i == er_at), 4'((seed + 5 * i) % 16), 1'b0);
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 4'((i * 3) % 16), 1'b0);
    endtask

    initial begin
        exp_pipe[0] = 5'b11111; exp_pipe[1] = 5'b11111;
        tag_pipe[0] = "R1";     tag_pipe[1] = "R1";
        repeat (3) @(negedge clk);
        check(5'b11111, "R1");
        rst_n = 1'b1;
        gap(3);
        for (int len = 1; len <= 20; len++) begin
            frame(len, len, (len % 4 == 0) ? len : -1);
            gap(len % 4);
        end
        gap(2);
        for (int v = 0; v < 32; v++)
            step(v[0], v[4], v[3:0], 1'b1);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 4'(i), 1'b0);
        step(1'b1, 1'b1, 4'hA, 1'b1);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 4'(i + 7), 1'b0);
        gap(4);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule